// File: doc/BRIEF.md
# TDM Control-Slot Port

This block owns one reserved 8-bit timeslot of a framed TDM serial link. A CPU writes a control byte into a register. While transmission is enabled, that byte goes out least significant bit first in the reserved slot of every outgoing frame. In the same slot of the incoming stream, the block shifts in the received byte and copies it as a whole into a status register that the CPU can read. The status register is refreshed once per frame. Traffic in all other slots belongs to other logic, and the block neither drives nor looks at it.

The block's clock is the line clock. A configuration bit states whether that clock runs at the bit rate (one clock per bit) or at twice the bit rate (two clocks per bit). A frame pulse, sampled on a clock edge, resets the bit position so that bit 0 of channel 0 begins in the following clock. A frame holds 32 channels of 8 bits, and the reserved slot is channel 1, which covers bit positions 8 to 15. Without a new pulse the position wraps after bit 255.

Top module: `cc_port`

## Requirements
- R1: After reset, the control byte, the configuration register and the status register all read 0, `ser_oe` is 0 and `ser_out` is 1.
- R2: Until the first frame pulse after reset, the block never drives the line and never updates the status register, whatever the configuration.
- R3: When the enable was set at the start of the slot, `ser_oe` is 1 during bit positions 8 to 15, and `ser_out` carries bit (position − 8) of the control byte, LSB first.
- R4: Outside positions 8 to 15, and inside them when the enable was clear at the start of the slot, `ser_oe` is 0 and `ser_out` is idle high.
- R5: Configuration bit 1 = 1 makes each bit last one clock. Bit 1 = 0 makes each bit last two clocks, and the input is sampled on the second of the two.
- R6: The serial input in positions 8 to 15 is assembled with the first bit received in bit 0. At the end of position 15 the result is written to the status register, in every frame.
- R7: The status register changes only at the end of the slot, so a read during the slot returns the previous frame's byte.
- R8: The control byte and the enable are latched as the slot begins. A write during the slot changes only the next frame.
- R9: Register map on `cpu_addr`: 0 = control byte (read/write); 1 = configuration, with bit 0 enable and bit 1 rate (read/write, other bits read 0); 2 = status (read-only, writes ignored); 3 reads 0.
- R10: A frame pulse at any position restarts the count at bit 0. Without a pulse, position 255 is followed by position 0 and the slot repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock, at 1× or 2× the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_pulse | input | 1 | Frame start; bit 0 begins in the clock after it is sampled |
| ser_in | input | 1 | Incoming serial stream |
| ser_out | output | 1 | Outgoing serial data, idle high when not driven |
| ser_oe | output | 1 | Output enable for the reserved slot |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 2 | Register select |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data (combinational) |

## Verification
The hardest case to reach is a CPU access that falls inside the reserved slot itself. This covers reading the status register while a new byte is half shifted, and rewriting the control byte or the enable while it is being sent. The stimulus walks the frame bit by bit from the bench and fires a write or a read at a chosen position, such as bit 10 or bit 12. It then keeps checking the line into the following frame, to see that the change appears there and not earlier. Random frames vary the byte values, the enable and the clock ratio. Directed runs cover the unsynchronised state, the natural wrap and a pulse in the middle of a frame.

// File: rtl/cc_pkg.sv
package cc_pkg;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_CFG    = 2'd1,
    REG_STATUS = 2'd2,
    REG_SPARE  = 2'd3
  } cc_reg_e;

  // Position after p in a frame of n bit periods.
  function automatic int unsigned wrap_inc(int unsigned p, int unsigned n);
    return (p + 1 == n) ? 0 : p + 1;
  endfunction

  // True when p lies in the window [first, first+len).
  function automatic logic in_window(int unsigned p, int unsigned first, int unsigned len);
    return (p >= first) && (p < first + len);
  endfunction

  // Position just ahead of the slot, taking the frame wrap into account.
  function automatic int unsigned pre_pos(int unsigned first, int unsigned n);
    return (first + n - 1) % n;
  endfunction

endpackage

// File: rtl/cc_slot_timer.sv
module cc_slot_timer #(
  parameter int unsigned FRAME_BITS = 256,
  parameter int unsigned SLOT_FIRST = 8,
  parameter int unsigned SLOT_LEN   = 8,
  localparam int unsigned CW = $clog2(FRAME_BITS),
  localparam int unsigned IW = $clog2(SLOT_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_pulse,
  input  logic          rate_full,
  output logic [CW-1:0] pos,
  output logic [IW-1:0] bit_idx,
  output logic          locked,
  output logic          slot_active,
  output logic          slot_load,
  output logic          slot_sample,
  output logic          slot_done
);
  localparam logic [CW-1:0] P_FIRST = CW'(SLOT_FIRST);
  localparam logic [CW-1:0] P_LAST  = CW'(SLOT_FIRST + SLOT_LEN - 1);
  localparam logic [CW-1:0] P_PRE   = CW'(cc_pkg::pre_pos(SLOT_FIRST, FRAME_BITS));

  logic half;
  logic bit_end;

  assign bit_end = rate_full | half;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos    <= '0;
      half   <= 1'b0;
      locked <= 1'b0;
    end else if (frame_pulse) begin
      pos    <= '0;
      half   <= 1'b0;
      locked <= 1'b1;
    end else begin
      half <= rate_full ? 1'b0 : ~half;
      if (bit_end) pos <= CW'(cc_pkg::wrap_inc(32'(pos), FRAME_BITS));
    end
  end

  assign slot_active = locked & cc_pkg::in_window(32'(pos), SLOT_FIRST, SLOT_LEN);
  assign slot_load   = locked & bit_end & ~frame_pulse & (pos == P_PRE);
  assign slot_sample = slot_active & bit_end & ~frame_pulse;
  assign slot_done   = slot_sample & (pos == P_LAST);
  assign bit_idx     = IW'(pos - P_FIRST);
endmodule

// File: rtl/cc_tx.sv
module cc_tx #(
  parameter int unsigned DW = 8,
  localparam int unsigned IW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          active,
  input  logic [DW-1:0] ctrl_byte,
  input  logic          tx_enable,
  input  logic [IW-1:0] idx,
  output logic [DW-1:0] hold,
  output logic          hold_en,
  output logic          ser_out,
  output logic          ser_oe
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold    <= '0;
      hold_en <= 1'b0;
    end else if (load) begin
      hold    <= ctrl_byte;
      hold_en <= tx_enable;
    end
  end

  assign ser_oe  = active & hold_en;
  assign ser_out = ser_oe ? hold[idx] : 1'b1;
endmodule

// File: rtl/cc_rx.sv
module cc_rx #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample,
  input  logic          done,
  input  logic          ser_in,
  output logic [DW-1:0] status
);
  logic [DW-1:0] shreg;
  logic [DW-1:0] shnext;

  assign shnext = {ser_in, shreg[DW-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg  <= '0;
      status <= '0;
    end else begin
      if (sample) shreg  <= shnext;
      if (done)   status <= shnext;
    end
  end
endmodule

// File: rtl/cc_regs.sv
module cc_regs #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr,
  input  logic [1:0]    cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic [DW-1:0] status,
  output logic [DW-1:0] ctrl_byte,
  output logic          tx_enable,
  output logic          rate_full,
  output logic [DW-1:0] cpu_rdata
);
  import cc_pkg::*;

  cc_reg_e sel;
  assign sel = cc_reg_e'(cpu_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_byte <= '0;
      tx_enable <= 1'b0;
      rate_full <= 1'b0;
    end else if (cpu_wr) begin
      if (sel == REG_CTRL) ctrl_byte <= cpu_wdata;
      if (sel == REG_CFG) begin
        tx_enable <= cpu_wdata[0];
        rate_full <= cpu_wdata[1];
      end
    end
  end

  always_comb begin
    case (sel)
      REG_CTRL:   cpu_rdata = ctrl_byte;
      REG_CFG:    cpu_rdata = {{(DW-2){1'b0}}, rate_full, tx_enable};
      REG_STATUS: cpu_rdata = status;
      default:    cpu_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cc_port.sv
module cc_port #(
  parameter int unsigned CH_BITS  = 8,
  parameter int unsigned FRAME_CH = 32,
  parameter int unsigned SLOT_CH  = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_pulse,
  input  logic               ser_in,
  output logic               ser_out,
  output logic               ser_oe,
  input  logic               cpu_wr,
  input  logic [1:0]         cpu_addr,
  input  logic [CH_BITS-1:0] cpu_wdata,
  output logic [CH_BITS-1:0] cpu_rdata
);
  localparam int unsigned FRAME_BITS = CH_BITS * FRAME_CH;
  localparam int unsigned SLOT_FIRST = CH_BITS * SLOT_CH;
  localparam int unsigned CW = $clog2(FRAME_BITS);
  localparam int unsigned IW = $clog2(CH_BITS);

  logic [CW-1:0]      pos;
  logic [IW-1:0]      bit_idx;
  logic               locked, slot_active, slot_load, slot_sample, slot_done;
  logic [CH_BITS-1:0] ctrl_byte, tx_hold, status;
  logic               tx_enable, rate_full, hold_en;

  cc_slot_timer #(.FRAME_BITS(FRAME_BITS), .SLOT_FIRST(SLOT_FIRST), .SLOT_LEN(CH_BITS)) u_timer (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .rate_full(rate_full),
    .pos(pos), .bit_idx(bit_idx), .locked(locked), .slot_active(slot_active),
    .slot_load(slot_load), .slot_sample(slot_sample), .slot_done(slot_done)
  );

  cc_tx #(.DW(CH_BITS)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(slot_load), .active(slot_active),
    .ctrl_byte(ctrl_byte), .tx_enable(tx_enable), .idx(bit_idx),
    .hold(tx_hold), .hold_en(hold_en), .ser_out(ser_out), .ser_oe(ser_oe)
  );

  cc_rx #(.DW(CH_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .sample(slot_sample), .done(slot_done),
    .ser_in(ser_in), .status(status)
  );

  cc_regs #(.DW(CH_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .status(status), .ctrl_byte(ctrl_byte),
    .tx_enable(tx_enable), .rate_full(rate_full), .cpu_rdata(cpu_rdata)
  );
endmodule

// File: rtl/cc_port_chk.sv
module cc_port_chk #(
  parameter int unsigned FRAME_BITS = 256,
  parameter int unsigned CW = 8,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_pulse,
  input logic          ser_out,
  input logic          ser_oe,
  input logic [CW-1:0] pos,
  input logic          locked,
  input logic          slot_active,
  input logic          slot_load,
  input logic          slot_done,
  input logic [DW-1:0] tx_hold,
  input logic          hold_en,
  input logic [DW-1:0] status
);
  AST_QUIET_OUTSIDE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_active |-> (!ser_oe && ser_out)); // R4
  AST_DISABLED_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_en |-> !ser_oe); // R4
  AST_UNLOCKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (!ser_oe && !slot_done)); // R2
  AST_PULSE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |=> (pos == '0 && locked)); // R10
  AST_POS_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pos) < FRAME_BITS); // R10
  AST_STATUS_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_done |=> $stable(status)); // R7
  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_active && !slot_load) |=> ($stable(tx_hold) && $stable(hold_en))); // R8
endmodule

bind cc_port cc_port_chk #(.FRAME_BITS(FRAME_BITS), .CW(CW), .DW(CH_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .ser_out(ser_out),
  .ser_oe(ser_oe), .pos(pos), .locked(locked), .slot_active(slot_active),
  .slot_load(slot_load), .slot_done(slot_done), .tx_hold(tx_hold),
  .hold_en(hold_en), .status(status)
);

// File: tb/cc_port_test.sv
module cc_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_pulse = 1'b0;
  logic       ser_in = 1'b1;
  logic       ser_out, ser_oe;
  logic       cpu_wr = 1'b0;
  logic [1:0] cpu_addr = 2'd0;
  logic [7:0] cpu_wdata = 8'd0;
  logic [7:0] cpu_rdata;

  always #5 clk = ~clk;

  cc_port uut (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .ser_in(ser_in),
    .ser_out(ser_out), .ser_oe(ser_oe), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // Bench view of the block, kept per bit period.
  logic [7:0] m_ctrl = 8'd0, m_status = 8'd0, m_hold = 8'd0;
  bit m_en = 1'b0, m_rate = 1'b0, m_hold_en = 1'b0, m_locked = 1'b0;

  function automatic bit slot_bit(int k);
    int f = k % 256;
    return f >= 8 && f <= 15;
  endfunction

  function automatic logic [7:0] cfg_value(bit rate, bit en);
    return {6'd0, rate, en};
  endfunction

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] v);
    cpu_addr = a; cpu_wdata = v; cpu_wr = 1'b1;
    cyc();
    cpu_wr = 1'b0;
    if (a == 2'd0) m_ctrl = v;
    if (a == 2'd1) begin m_en = v[0]; m_rate = v[1]; end
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
    cpu_addr = a;
    #1;
    cmp(tag, cpu_rdata, exp);
  endtask

  task automatic pulse();
    frame_pulse = 1'b1;
    cyc();
    frame_pulse = 1'b0;
    m_locked = 1'b1;
  endtask

  // Walk bit periods first..first+n-1 of the frame, checking the line every clock.
  task automatic run_bits(int first, int n, logic [7:0] rxb,
                          int wr_bit, logic [1:0] wr_addr, logic [7:0] wr_val, int rd_bit);
    for (int k = first; k < first + n; k++) begin
      int f = k % 256;
      if (f == 8 && m_locked) begin m_hold = m_ctrl; m_hold_en = m_en; end
      for (int c = 0; c < (m_rate ? 1 : 2); c++) begin
        bit exp_oe;
        logic exp_d;
        string tag;
        ser_in = slot_bit(k) ? rxb[f-8] : 1'($urandom);
        exp_oe = m_locked && slot_bit(k) && m_hold_en;
        exp_d  = exp_oe ? m_hold[f-8] : 1'b1;
        if (!m_locked) tag = "R2 unlocked";
        else if (exp_oe) tag = m_rate ? "R3 R5 slot bit" : "R3 slot bit";
        else tag = "R4 idle";
        #1;
        cmp({tag, " oe"}, ser_oe, exp_oe);
        cmp({tag, " data"}, ser_out, exp_d);
        if (k == rd_bit && c == 0) rd(2'd2, m_status, "R7 status read mid-slot");
        if (k == wr_bit && c == 0) begin
          cpu_addr = wr_addr; cpu_wdata = wr_val; cpu_wr = 1'b1;
        end
        cyc();
        if (k == wr_bit && c == 0) begin
          cpu_wr = 1'b0;
          if (wr_addr == 2'd0) m_ctrl = wr_val;
          if (wr_addr == 2'd1) m_en = wr_val[0];
        end
      end
      if (f == 15 && m_locked) m_status = rxb;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    void'($urandom(32'd91357));
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();

    // R1: reset values
    rd(2'd0, 8'h00, "R1 ctrl after reset");
    rd(2'd1, 8'h00, "R1 cfg after reset");
    rd(2'd2, 8'h00, "R1 status after reset");
    cmp("R1 oe after reset", ser_oe, 1'b0);
    cmp("R1 data after reset", ser_out, 1'b1);

    // R2: enabled but never framed
    wr(2'd0, 8'hA5);
    wr(2'd1, cfg_value(1'b0, 1'b1));
    run_bits(0, 300, 8'h5E, -1, 2'd0, 8'd0, -1);
    rd(2'd2, 8'h00, "R2 status untouched before lock");

    // R9: register map
    wr(2'd1, 8'hFF);
    rd(2'd1, 8'h03, "R9 cfg upper bits read 0");
    wr(2'd2, 8'h5A);
    rd(2'd2, 8'h00, "R9 status write ignored");
    rd(2'd3, 8'h00, "R9 spare reads 0");
    rd(2'd0, 8'hA5, "R9 ctrl readback");
    wr(2'd1, cfg_value(1'b0, 1'b1));

    // R3 R6 R7: first framed frame, double-rate clock, then R10 natural wrap
    pulse();
    run_bits(0, 256, 8'h3C, -1, 2'd0, 8'd0, 12);
    rd(2'd2, 8'h3C, "R6 status after frame");
    run_bits(256, 24, 8'hC3, -1, 2'd0, 8'd0, 266);
    rd(2'd2, 8'hC3, "R10 status after wrapped frame");

    // R8: control byte rewritten mid-slot, then enable cleared mid-slot
    pulse();
    run_bits(0, 256, 8'h81, 10, 2'd0, 8'h0F, -1);
    pulse();
    run_bits(0, 256, 8'h7E, 11, 2'd1, cfg_value(1'b0, 1'b0), 13);
    pulse();
    run_bits(0, 20, 8'h99, -1, 2'd0, 8'd0, -1);
    rd(2'd2, 8'h99, "R6 status updated while tx disabled");

    // R10: pulse in the middle of a frame restarts the count
    wr(2'd1, cfg_value(1'b0, 1'b1));
    pulse();
    run_bits(0, 5, 8'h00, -1, 2'd0, 8'd0, -1);
    pulse();
    run_bits(0, 20, 8'h42, -1, 2'd0, 8'd0, -1);
    rd(2'd2, 8'h42, "R10 status after restarted frame");

    // R5: bit-rate clock
    wr(2'd0, 8'h6B);
    wr(2'd1, cfg_value(1'b1, 1'b1));
    pulse();
    run_bits(0, 256, 8'hD4, -1, 2'd0, 8'd0, 12);
    rd(2'd2, 8'hD4, "R5 R6 status at bit-rate clock");

    // Random frames
    for (int i = 0; i < 10; i++) begin
      wr(2'd0, 8'($urandom));
      wr(2'd1, cfg_value(1'($urandom), ($urandom % 4) != 0));
      rv = 8'($urandom);
      pulse();
      run_bits(0, (i % 2 == 0) ? 256 : 24, rv, -1, 2'd0, 8'd0, 9 + (i % 6));
      rd(2'd2, rv, "R6 status random frame");
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule